// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

The block steps a multi-channel analog-to-digital converter through a set of inputs chosen by two 3-bit fields. The mode field picks the kind of run: one channel, a scan inside one of two four-channel groups, or a scan over all eight inputs. The channel field picks the single input, or the top input of the scan. For each input the block sends a one-cycle start pulse with a channel index to an external converter. It then waits for the done pulse and files the returned word in a result register that belongs to that input.

Software starts a run with one write to the control register. It watches a completion flag and reads results over a simple register bus. A DMA engine can take results through a separate read port. The completion flag can be cleared in two ways: by software reading it as 1 and then writing 0, or by any DMA read. One mode bit makes the block repeat the scan until software asks it to stop.

Register bus: address 0 is the control register. Addresses 8 to 15 return result registers 0 to 7 (address bit 3 set, channel index in bits 2:0). All other addresses read as zero. On a control write, bits 2:0 carry the channel field, bits 5:3 the mode field, bit 6 the start bit and bit 7 the flag bit. On a control read, bits 2:0 return the channel field, bits 5:3 the mode field, bit 6 busy and bit 7 the completion flag.

Top module: `adc_scan_seq`

## Requirements
- R1: When mode bit 2 is 0, a run converts only input n, where n is the channel code.
- R2: In modes 100 and 110 with a channel code c from 000 to 011, a run covers inputs 0 to c.
- R3: In modes 100 and 110 with a channel code c from 100 to 111, a run covers inputs 4 to c.
- R4: In modes 101 and 111, a run covers inputs 0 to c for any channel code c.
- R5: After reset the control register reads 0 (channel 000, mode 000, not busy, flag clear), every result register reads 0 and no start pulse is given.
- R6: A pass converts its inputs in ascending order, and each result lands in the register with the same index as its input.
- R7: The completion flag rises when the last input of a pass completes. If a clear request comes in that same cycle, the flag is still set.
- R8: Writing 0 to control bit 7 clears the flag only when a control read has returned the flag as 1 since the last control write. Otherwise the write leaves the flag set. Writing 1 to bit 7 never changes the flag.
- R9: A DMA read of any result register clears the completion flag.
- R10: When mode bit 1 is 0 the block returns to idle after one pass. When it is 1 the block starts the pass again from its first input. In that case, a control write with bit 6 at 0 made during a run ends the run after the current pass.
- R11: While busy, control writes do not change the mode or channel fields, and a start bit has no effect. In idle, a control write loads both fields, and bit 6 at 1 starts a pass with the loaded values.
- R12: A start pulse lasts exactly one cycle. After it, the block stays busy and gives no further start pulse until the converter returns done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (a read of address 0 arms the flag clear) |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Register read data, combinational from rd_addr |
| dma_rd | input | 1 | DMA read strobe |
| dma_idx | input | 3 | Result register picked for the DMA read |
| dma_data | output | DW | DMA read data |
| cv_start | output | 1 | One-cycle conversion request |
| cv_chan | output | 3 | Input index for the current conversion |
| cv_done | input | 1 | Converter completion pulse |
| cv_result | input | DW | Converter result, valid with cv_done |
| busy | output | 1 | A pass or a repeated run is in progress |
| eoc | output | 1 | Completion flag |

## Verification
Two events can meet in one cycle: the flag being set by the last done of a pass, and a flag clear from a DMA read. The bench runs a repeating two-input scan and clears the flag through DMA after the first pass. In the second pass it drives the DMA read strobe in the same cycle as the final done pulse. The flag must read 1 afterwards, because setting takes priority over clearing.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int NCH = 8;
    localparam int CHW = $clog2(NCH);

    // control register bit positions
    localparam int CTL_GO  = 6;
    localparam int CTL_EOC = 7;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_t;

    // lowest input of the set; the highest input always equals the channel code
    function automatic logic [CHW-1:0] scan_first(input logic [2:0] mode,
                                                  input logic [CHW-1:0] chan);
        logic [CHW-1:0] f;
        if (!mode[2])
            f = chan;
        else if (!mode[0] && chan[CHW-1])
            f = CHW'(NCH / 2);
        else
            f = '0;
        return f;
    endfunction

endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctl_wr,
    input  logic [2:0]     wr_mode,
    input  logic [CHW-1:0] wr_chan,
    input  logic           wr_go,
    input  logic [CHW-1:0] held_first,
    input  logic           cv_done,
    output logic [2:0]     mode_q,
    output logic [CHW-1:0] chan_q,
    output logic           busy,
    output logic           cv_start,
    output logic [CHW-1:0] cv_chan,
    output logic           res_we,
    output logic           pass_end
);

    typedef struct packed {
        seq_state_t     st;
        logic [2:0]     mode;
        logic [CHW-1:0] chan;
        logic [CHW-1:0] cur;
        logic           stop;
    } ctrl_t;

    ctrl_t q, d;
    logic  halt_now;
    logic  at_last;

    always_comb begin
        d        = q;
        res_we   = 1'b0;
        pass_end = 1'b0;
        halt_now = q.stop | (ctl_wr & ~wr_go);
        at_last  = (q.cur == q.chan);

        if (q.st != SQ_IDLE && ctl_wr && !wr_go)
            d.stop = 1'b1;

        case (q.st)
            SQ_IDLE: begin
                if (ctl_wr) begin
                    d.mode = wr_mode;
                    d.chan = wr_chan;
                    if (wr_go) begin
                        d.st   = SQ_ISSUE;
                        d.cur  = scan_first(wr_mode, wr_chan);
                        d.stop = 1'b0;
                    end
                end
            end
            SQ_ISSUE: begin
                d.st = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (cv_done) begin
                    res_we = 1'b1;
                    if (at_last) begin
                        pass_end = 1'b1;
                        if (q.mode[1] && !halt_now) begin
                            d.cur = held_first;
                            d.st  = SQ_ISSUE;
                        end else begin
                            d.st   = SQ_IDLE;
                            d.stop = 1'b0;
                        end
                    end else begin
                        d.cur = q.cur + 1'b1;
                        d.st  = SQ_ISSUE;
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= SQ_IDLE;
            q.mode <= '0;
            q.chan <= '0;
            q.cur  <= '0;
            q.stop <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign mode_q   = q.mode;
    assign chan_q   = q.chan;
    assign busy     = (q.st != SQ_IDLE);
    assign cv_start = (q.st == SQ_ISSUE);
    assign cv_chan  = q.cur;

endmodule

// File: rtl/adc_eoc_flag.sv
module adc_eoc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic ctl_rd,
    input  logic ctl_wr,
    input  logic wr_flag_bit,
    input  logic dma_rd,
    output logic flag
);

    typedef struct packed {
        logic flag;
        logic armed;
    } eoc_t;

    eoc_t q, d;

    always_comb begin
        d = q;
        if (ctl_rd && q.flag)
            d.armed = 1'b1;
        if (ctl_wr) begin
            if (!wr_flag_bit && q.armed)
                d.flag = 1'b0;
            d.armed = 1'b0;
        end
        if (dma_rd) begin
            d.flag  = 1'b0;
            d.armed = 1'b0;
        end
        if (set_pulse)
            d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.flag  <= 1'b0;
            q.armed <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign flag = q.flag;

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_scan_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [CHW-1:0] widx,
    input  logic [DW-1:0]  wdata,
    input  logic [CHW-1:0] ridx_a,
    output logic [DW-1:0]  rdata_a,
    input  logic [CHW-1:0] ridx_b,
    output logic [DW-1:0]  rdata_b
);

    logic [DW-1:0] slot_q [NCH];
    logic [DW-1:0] slot_d [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_slot
        always_comb begin
            slot_d[i] = slot_q[i];
            if (we && widx == CHW'(i))
                slot_d[i] = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else
                slot_q[i] <= slot_d[i];
        end
    end

    assign rdata_a = slot_q[ridx_a];
    assign rdata_b = slot_q[ridx_b];

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int DW = 12,
    parameter int AW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [7:0]     wr_data,
    input  logic           rd_en,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data,
    input  logic           dma_rd,
    input  logic [CHW-1:0] dma_idx,
    output logic [DW-1:0]  dma_data,
    output logic           cv_start,
    output logic [CHW-1:0] cv_chan,
    input  logic           cv_done,
    input  logic [DW-1:0]  cv_result,
    output logic           busy,
    output logic           eoc
);

    localparam int PADW = DW - 8;

    logic           ctl_wr;
    logic           ctl_rd;
    logic [2:0]     mode_q;
    logic [CHW-1:0] chan_q;
    logic [CHW-1:0] held_first;
    logic           res_we;
    logic           pass_end;
    logic [DW-1:0]  bank_rd;
    logic [7:0]     status;

    assign ctl_wr     = wr_en && (wr_addr == '0);
    assign ctl_rd     = rd_en && (rd_addr == '0);
    assign held_first = scan_first(mode_q, chan_q);

    adc_scan_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .wr_mode    (wr_data[5:3]),
        .wr_chan    (wr_data[2:0]),
        .wr_go      (wr_data[CTL_GO]),
        .held_first (held_first),
        .cv_done    (cv_done),
        .mode_q     (mode_q),
        .chan_q     (chan_q),
        .busy       (busy),
        .cv_start   (cv_start),
        .cv_chan    (cv_chan),
        .res_we     (res_we),
        .pass_end   (pass_end)
    );

    adc_eoc_flag u_eoc (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_pulse   (pass_end),
        .ctl_rd      (ctl_rd),
        .ctl_wr      (ctl_wr),
        .wr_flag_bit (wr_data[CTL_EOC]),
        .dma_rd      (dma_rd),
        .flag        (eoc)
    );

    adc_result_bank #(.DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (res_we),
        .widx    (cv_chan),
        .wdata   (cv_result),
        .ridx_a  (rd_addr[CHW-1:0]),
        .rdata_a (bank_rd),
        .ridx_b  (dma_idx),
        .rdata_b (dma_data)
    );

    assign status = {eoc, busy, mode_q, chan_q};

    always_comb begin
        if (rd_addr == '0)
            rd_data = {{PADW{1'b0}}, status};
        else if (rd_addr[AW-1])
            rd_data = bank_rd;
        else
            rd_data = '0;
    end

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cv_start,
    input logic [2:0] cv_chan,
    input logic       busy,
    input logic       eoc,
    input logic       pass_end,
    input logic       dma_rd,
    input logic [2:0] mode_q,
    input logic [2:0] chan_q,
    input logic [2:0] held_first
);

    a_r12_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        cv_start |=> !cv_start);

    a_r12_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cv_start |-> busy);

    a_r6_chan_in_set: assert property (@(posedge clk) disable iff (!rst_n)
        cv_start |-> (cv_chan >= held_first && cv_chan <= chan_q));

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pass_end |=> eoc);

    a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_end && !eoc) |=> !eoc);

    a_r9_dma_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd && !pass_end) |=> !eoc);

    a_r11_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(mode_q) && $stable(chan_q)));

endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cv_start   (cv_start),
    .cv_chan    (cv_chan),
    .busy       (busy),
    .eoc        (eoc),
    .pass_end   (pass_end),
    .dma_rd     (dma_rd),
    .mode_q     (mode_q),
    .chan_q     (chan_q),
    .held_first (held_first)
);

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;

    localparam int DW = 12;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          dma_rd = 1'b0;
    logic [2:0]    dma_idx = '0;
    logic [DW-1:0] dma_data;
    logic          cv_start;
    logic [2:0]    cv_chan;
    logic          cv_done = 1'b0;
    logic [DW-1:0] cv_result = '0;
    logic          busy;
    logic          eoc;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    adc_scan_seq #(.DW(DW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .dma_rd(dma_rd), .dma_idx(dma_idx), .dma_data(dma_data),
        .cv_start(cv_start), .cv_chan(cv_chan),
        .cv_done(cv_done), .cv_result(cv_result),
        .busy(busy), .eoc(eoc)
    );

    function automatic logic [DW-1:0] res_val(input int tag, input int ch);
        return DW'(tag * 16 + ch);
    endfunction

    function automatic logic [7:0] ctl_word(input bit go, input logic [2:0] mode,
                                            input logic [2:0] chan);
        return {1'b1, go, mode, chan};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [7:0] data);
        wr_en = 1'b1; wr_addr = '0; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cpu_read(input logic [AW-1:0] addr, output logic [DW-1:0] data);
        rd_en = 1'b1; rd_addr = addr;
        #1 data = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic dma_take(input logic [2:0] idx, input logic [DW-1:0] exp, input string req);
        dma_rd = 1'b1; dma_idx = idx;
        #1 check(req, dma_data, exp);
        @(negedge clk);
        dma_rd = 1'b0;
    endtask

    // converter model: answer the pending request after it has been issued
    task automatic serve(input int exp_ch, input int tag, input bit with_dma, input string req);
        @(negedge clk);
        check(req, {cv_start, busy, cv_chan}, {1'b0, 1'b1, 3'(exp_ch)});
        cv_done = 1'b1; cv_result = res_val(tag, exp_ch);
        dma_rd = with_dma;
        @(negedge clk);
        cv_done = 1'b0; dma_rd = 1'b0;
    endtask

    task automatic expect_slot(input int ch, input int tag, input string req);
        logic [DW-1:0] v;
        cpu_read(4'(8 + ch), v);
        check(req, v, (tag < 0) ? '0 : res_val(tag, ch));
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        cpu_read('0, v);
        check("R5 ctrl", v, '0);
        check("R5 eoc/start/busy", {eoc, cv_start, busy}, 3'b000);
        expect_slot(3, -1, "R5 slot3");
        expect_slot(7, -1, "R5 slot7");
    endtask

    task automatic t_single;
        cpu_write(ctl_word(1'b1, 3'b000, 3'd5));
        check("R12 start pulse", {cv_start, cv_chan}, {1'b1, 3'd5});
        serve(5, 1, 1'b0, "R1 single AN5");
        check("R10 idle after pass", {busy, eoc}, 2'b01);
        expect_slot(5, 1, "R6 slot5");
        expect_slot(4, -1, "R1 slot4 untouched");
        dma_take(3'd5, res_val(1, 5), "R9 dma data");
        check("R9 dma clears", eoc, 1'b0);
    endtask

    task automatic t_group_low;
        logic [DW-1:0] v;
        cpu_write(ctl_word(1'b1, 3'b100, 3'd2));
        for (int c = 0; c <= 2; c++) serve(c, 2, 1'b0, "R2 order");
        check("R2 done", {busy, eoc}, 2'b01);
        for (int c = 0; c <= 2; c++) expect_slot(c, 2, "R6 slot");
        expect_slot(3, -1, "R2 slot3 untouched");
        cpu_write(8'h00);
        check("R8 zero without read", eoc, 1'b1);
        cpu_read('0, v);
        check("R8 ctrl read", v, 12'h080);
        cpu_write(8'h80);
        check("R8 write one keeps", eoc, 1'b1);
        cpu_read('0, v);
        cpu_write(8'h00);
        check("R8 read then zero", eoc, 1'b0);
    endtask

    task automatic t_group_high;
        cpu_write(ctl_word(1'b1, 3'b100, 3'd6));
        for (int c = 4; c <= 6; c++) serve(c, 3, 1'b0, "R3 order");
        check("R3 done", {busy, eoc}, 2'b01);
        for (int c = 4; c <= 6; c++) expect_slot(c, 3, "R3 slot");
        expect_slot(7, -1, "R3 slot7 untouched");
        expect_slot(0, 2, "R3 slot0 untouched");
        dma_take(3'd4, res_val(3, 4), "R9 dma group");
    endtask

    task automatic t_eight;
        logic [DW-1:0] v;
        cpu_write(ctl_word(1'b1, 3'b101, 3'd7));
        serve(0, 4, 1'b0, "R4 order");
        cpu_write(ctl_word(1'b1, 3'b000, 3'd1));
        cpu_read('0, v);
        check("R11 fields held", v, 12'h06F);
        for (int c = 1; c <= 7; c++) serve(c, 4, 1'b0, "R4 order");
        check("R4 done", {busy, eoc}, 2'b01);
        for (int c = 0; c <= 7; c++) expect_slot(c, 4, "R4 slot");
        dma_take(3'd7, res_val(4, 7), "R9 dma eight");
    endtask

    task automatic t_repeat;
        cpu_write(ctl_word(1'b1, 3'b110, 3'd5));
        serve(4, 5, 1'b0, "R10 pass1");
        serve(5, 5, 1'b0, "R10 pass1");
        check("R10 restart", {busy, eoc, cv_start, cv_chan}, {3'b111, 3'd4});
        dma_take(3'd5, res_val(5, 5), "R9 dma during run");
        check("R9 cleared in run", eoc, 1'b0);
        cpu_write(8'h00);
        serve(4, 6, 1'b0, "R10 pass2");
        serve(5, 6, 1'b1, "R10 pass2");
        check("R7 set wins over dma", eoc, 1'b1);
        check("R10 stop after pass", busy, 1'b0);
        expect_slot(5, 6, "R6 slot5 pass2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_group_low();
        t_group_high();
        t_eight();
        t_repeat();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule